// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Controller

This block holds the status byte of a small serial memory with 512 bytes and decides whether each array write may go ahead. A host on an SPI slave port (mode 0) can read the status byte, write the two protection bits, and set or clear the write-enable latch. The memory's array-write logic sends each target address on a request port and gets back one grant or one deny pulse. A grant starts a fixed-length internal write cycle.

The SPI pins are oversampled by the system clock after a synchronizer. The data-out pin comes as a data bit with an output enable; the pad drives high impedance whenever the enable is low. The two protection bits sit in an ordinary register standing in for persistent storage. That register changes only through a committed status write or through `rst_n`. While a write cycle runs, the busy flag is high. When the cycle finishes, the enable latch clears.

Top module: `smem_status_guard`

## Requirements
- R1: Status read. The status byte is bits 7..4 = 0, bit 3 = BP1, bit 2 = BP0, bit 1 = enable latch, bit 0 = busy. It is read with opcode 0x05: eight opcode bits are sampled on SI at rising SCK, then the byte is shifted out MSB first on SO. SO changes after each falling SCK. The byte repeats while CS stays low.
- R2: The output enable is low except in the data phase of a status read. This covers CS high, the opcode bits, and every other command.
- R3: Opcode 0x06 sets the enable latch and 0x04 clears it, whatever BP holds. Either command acts only if CS rises after exactly 8 bits. Any other length is ignored.
- R4: A status write is opcode 0x01 plus one data byte. It commits only if CS rises after exactly 16 bits, the enable latch is 1 and no write cycle runs. On commit, BP1/BP0 take data bits 3/2 and a write cycle of WRITE_CYCLES clocks starts. All other data bits are dropped. If the write does not commit, nothing changes.
- R5: When a write cycle completes, the enable latch is cleared.
- R6: Protection for a 9-bit address is selected by BP. BP=00 locks nothing. BP=01 locks 0x180..0x1FF. BP=10 locks 0x100..0x1FF. BP=11 locks every address.
- R7: Every cycle with `wr_req` high produces exactly one response one clock later. The response is `wr_grant` if the latch is 1, no write cycle runs and the address is unlocked; otherwise it is `wr_deny`. A grant starts a write cycle, and the busy output is high from the grant on.
- R8: The status byte can be read during a write cycle, and then shows busy = 1.
- R9: During a write cycle, latch commands, status writes and array requests are ignored or denied.
- R10: A granted array request and a status-write commit may fall on the same clock. The array request then wins, and the status write is dropped with BP unchanged.
- R11: After reset the latch is 0, busy is 0, BP = BP_RESET, the output enable is low and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock |
| spi_si | input | 1 | SPI serial data in |
| spi_so | output | 1 | SPI serial data out (valid while enable high) |
| spi_so_en | output | 1 | Output enable for the SO pad; low means high impedance |
| wr_req | input | 1 | Array write request strobe |
| wr_addr | input | ADDR_W | Array address of the request |
| wr_grant | output | 1 | Request allowed; write cycle started |
| wr_deny | output | 1 | Request refused; state unchanged |
| write_busy | output | 1 | Internal write cycle running |

## Verification
Two events can land on one clock edge: the CS release that commits a status write, and an array request that is eligible for a grant. The bench provokes this by raising CS and then asserting `wr_req` exactly the synchronizer latency later, so both reach the decision logic on the same edge. It judges the outcome by three observations: a grant pulse, the busy flag set by the array write, and a later status read showing the protection bits unchanged while the latch is cleared by the finished cycle.

// File: rtl/smg_pkg.sv
package smg_pkg;
   localparam logic [7:0] OP_STAT_RD  = 8'h05;
   localparam logic [7:0] OP_STAT_WR  = 8'h01;
   localparam logic [7:0] OP_LATCH_ON = 8'h06;
   localparam logic [7:0] OP_LATCH_OFF = 8'h04;

   typedef struct packed {
      logic [3:0] spare;
      logic [1:0] bp;
      logic       wel;
      logic       wip;
   } stat_t;

   typedef enum logic [1:0] {
      FLEN_OTHER = 2'd0,
      FLEN_BYTE  = 2'd1,
      FLEN_WORD  = 2'd2
   } flen_t;
endpackage

// File: rtl/smg_sync.sv
module smg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg <= {STAGES{RST_VAL}};
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/smg_spi_front.sv
module smg_spi_front
   import smg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       si,
   input  stat_t      status,
   output logic       so_d,
   output logic       so_en,
   output logic       end_evt,
   output flen_t      end_len,
   output logic [7:0] end_op,
   output logic [7:0] end_data
);
   localparam int CNT_W = 5;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             sck_q, cs_q;
   logic [CNT_W-1:0] bit_cnt;
   logic [15:0]      in_sh;
   logic [7:0]       op_q;
   logic             rd_mode;
   logic [7:0]       out_sh;
   logic [2:0]       out_idx;
   logic             sck_rise, sck_fall;
   logic [7:0]       first_byte;

   assign sck_rise   = sck & ~sck_q & ~cs_n;
   assign sck_fall   = ~sck & sck_q & ~cs_n;
   assign first_byte = {in_sh[6:0], si};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         cs_q    <= 1'b1;
         bit_cnt <= '0;
         in_sh   <= '0;
         op_q    <= '0;
         rd_mode <= 1'b0;
         out_sh  <= '0;
         out_idx <= '0;
         so_d    <= 1'b0;
         so_en   <= 1'b0;
      end else begin
         sck_q <= sck;
         cs_q  <= cs_n;
         if (cs_n) begin
            bit_cnt <= '0;
            rd_mode <= 1'b0;
            out_idx <= '0;
            so_en   <= 1'b0;
         end else begin
            if (sck_rise) begin
               in_sh <= {in_sh[14:0], si};
               if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(7)) begin
                  op_q    <= first_byte;
                  rd_mode <= (first_byte == OP_STAT_RD);
               end
            end
            if (sck_fall && rd_mode) begin
               so_en <= 1'b1;
               if (out_idx == 3'd0) begin
                  so_d   <= status[7];
                  out_sh <= {status[6:0], 1'b0};
               end else begin
                  so_d   <= out_sh[7];
                  out_sh <= {out_sh[6:0], 1'b0};
               end
               out_idx <= out_idx + 1'b1;
            end
         end
      end
   end

   assign end_evt  = cs_n & ~cs_q;
   assign end_op   = op_q;
   assign end_data = in_sh[7:0];

   always_comb begin
      if (bit_cnt == CNT_W'(8))       end_len = FLEN_BYTE;
      else if (bit_cnt == CNT_W'(16)) end_len = FLEN_WORD;
      else                            end_len = FLEN_OTHER;
   end
endmodule

// File: rtl/smg_protect.sv
module smg_protect #(
   parameter int ADDR_W = 9
) (
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              locked
);
   logic [1:0] top2;
   assign top2 = addr[ADDR_W-1 -: 2];

   always_comb begin
      unique case (bp)
         2'b00:   locked = 1'b0;
         2'b01:   locked = (top2 == 2'b11);
         2'b10:   locked = addr[ADDR_W-1];
         default: locked = 1'b1;
      endcase
   end
endmodule

// File: rtl/smg_wtimer.sv
module smg_wtimer #(
   parameter int CYCLES = 600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int TW = $clog2(CYCLES + 1);
   localparam logic [TW-1:0] LOAD = TW'(CYCLES);

   logic [TW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (start && remain == '0) begin
         remain <= LOAD;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign busy = (remain != '0);
   assign done = (remain == TW'(1));
endmodule

// File: rtl/smem_status_guard.sv
module smem_status_guard
   import smg_pkg::*;
#(
   parameter int         ADDR_W       = 9,
   parameter int         WRITE_CYCLES = 600,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [1:0] BP_RESET     = 2'b00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_si,
   output logic              spi_so,
   output logic              spi_so_en,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              wr_grant,
   output logic              wr_deny,
   output logic              write_busy
);
   generate
      if (ADDR_W < 2)       begin : g_bad_aw  $error("ADDR_W must be at least 2"); end
      if (WRITE_CYCLES < 1) begin : g_bad_wc  $error("WRITE_CYCLES must be at least 1"); end
      if (SYNC_STAGES < 0)  begin : g_bad_ss  $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic       cs_s, sck_s, si_s;
   logic       end_evt;
   flen_t      end_len;
   logic [7:0] end_op, end_data;
   logic       locked, busy, tmr_done;
   logic       wel_q;
   logic [1:0] bp_q;
   stat_t      stat;
   logic       arr_ok, cmd_byte, wrsr_ok, start;

   smg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync
      (.clk(clk), .rst_n(rst_n), .d(spi_cs_n), .q(cs_s));
   smg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync
      (.clk(clk), .rst_n(rst_n), .d(spi_sck), .q(sck_s));
   smg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_si_sync
      (.clk(clk), .rst_n(rst_n), .d(spi_si), .q(si_s));

   assign stat.spare = 4'h0;
   assign stat.bp    = bp_q;
   assign stat.wel   = wel_q;
   assign stat.wip   = busy;

   smg_spi_front u_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_s), .sck(sck_s), .si(si_s),
      .status(stat), .so_d(spi_so), .so_en(spi_so_en),
      .end_evt(end_evt), .end_len(end_len), .end_op(end_op), .end_data(end_data)
   );

   smg_protect #(.ADDR_W(ADDR_W)) u_prot (.bp(bp_q), .addr(wr_addr), .locked(locked));

   smg_wtimer #(.CYCLES(WRITE_CYCLES)) u_tmr
      (.clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(tmr_done));

   assign arr_ok   = wr_req & wel_q & ~busy & ~locked;
   assign cmd_byte = end_evt & (end_len == FLEN_BYTE) & ~busy;
   assign wrsr_ok  = end_evt & (end_len == FLEN_WORD) & (end_op == OP_STAT_WR)
                   & wel_q & ~busy & ~arr_ok;
   assign start    = arr_ok | wrsr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q    <= 1'b0;
         bp_q     <= BP_RESET;
         wr_grant <= 1'b0;
         wr_deny  <= 1'b0;
      end else begin
         wr_grant <= arr_ok;
         wr_deny  <= wr_req & ~arr_ok;
         if (wrsr_ok) bp_q <= end_data[3:2];
         if (tmr_done)                              wel_q <= 1'b0;
         else if (cmd_byte && end_op == OP_LATCH_ON)  wel_q <= 1'b1;
         else if (cmd_byte && end_op == OP_LATCH_OFF) wel_q <= 1'b0;
      end
   end

   assign write_busy = busy;
endmodule

// File: rtl/smg_checker.sv
module smg_checker #(
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_s,
   input logic              so_en,
   input logic              wr_req,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_grant,
   input logic              wr_deny,
   input logic              busy,
   input logic              wel,
   input logic [1:0]        bp
);
   assert_so_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !so_en);

   assert_one_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> (wr_grant ^ wr_deny));

   assert_no_stray_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> !(wr_grant || wr_deny));

   assert_latch_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wel) |=> wr_deny);

   assert_grant_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_grant |-> busy);

   assert_full_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && bp == 2'b11) |=> wr_deny);

   assert_upper_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && bp == 2'b01 && wr_addr[ADDR_W-1 -: 2] == 2'b11) |=> wr_deny);

   assert_busy_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && busy) |=> wr_deny);

   assert_bp_only_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bp != $past(bp)) |-> $rose(busy));

   assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel);
endmodule

bind smem_status_guard smg_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .so_en(spi_so_en),
   .wr_req(wr_req), .wr_addr(wr_addr), .wr_grant(wr_grant), .wr_deny(wr_deny),
   .busy(write_busy), .wel(wel_q), .bp(bp_q)
);

// File: tb/sim_smem_status_guard.sv
module sim_smem_status_guard;
   localparam int AW = 9, WC = 600, HALF = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wr_req = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic spi_so, spi_so_en, wr_grant, wr_deny, write_busy;

   int   n_chk = 0, n_fail = 0;
   bit   m_wel = 1'b0;
   logic [1:0] m_bp = 2'b00;

   always #10 clk = ~clk;

   smem_status_guard #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
      .spi_so(spi_so), .spi_so_en(spi_so_en), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_grant(wr_grant), .wr_deny(wr_deny), .write_busy(write_busy)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_lock(input logic [1:0] bp, input logic [AW-1:0] a);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return a >= 9'h180;
         2'b10:   return a >= 9'h100;
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [7:0] exp_stat(input bit busy_now);
      return {4'h0, m_bp, m_wel, busy_now};
   endfunction

   task automatic frame_open(input int nbits, input logic [15:0] tx,
                             output logic [7:0] rx, output int early, output int late);
      rx = '0; early = 0; late = 0;
      cs_n = 1'b0;
      tick(4);
      for (int i = 0; i < nbits; i++) begin
         sck = 1'b0;
         si  = tx[nbits-1-i];
         tick(HALF);
         if (spi_so_en) begin
            if (i < 8) early++;
            else       late++;
         end
         if (i >= 8) rx = {rx[6:0], spi_so};
         sck = 1'b1;
         tick(HALF);
      end
      sck = 1'b0;
      tick(HALF);
   endtask

   task automatic frame_close();
      cs_n = 1'b1;
      tick(8);
      check(!spi_so_en, "R2 enable after CS high", spi_so_en, 0);
   endtask

   task automatic send(input int nbits, input logic [15:0] tx);
      logic [7:0] rx;
      int e, l;
      frame_open(nbits, tx, rx, e, l);
      frame_close();
      check(e + l == 0, "R2 enable during non-read frame", e + l, 0);
   endtask

   task automatic status_check(input string tag, input bit busy_now);
      logic [7:0] rx;
      int e, l;
      frame_open(16, {8'h05, 8'h00}, rx, e, l);
      frame_close();
      check(rx == exp_stat(busy_now), tag, rx, exp_stat(busy_now));
      check(e == 0 && l == 8, "R1 R2 enable only in data phase", e * 16 + l, 8);
   endtask

   task automatic wait_idle();
      int k = 0;
      while (write_busy && k < 5000) begin
         tick(1);
         k++;
      end
   endtask

   task automatic status_write(input logic [7:0] d);
      bit commit;
      commit = m_wel;
      send(16, {8'h01, d});
      check(write_busy == commit, "R4 status write commit", write_busy, commit);
      if (commit) begin
         m_bp = d[3:2];
         wait_idle();
         m_wel = 1'b0;
      end
   endtask

   task automatic latch(input bit on);
      send(8, on ? 16'h0006 : 16'h0004);
      m_wel = on;
   endtask

   task automatic arr(input logic [AW-1:0] a, input string tag);
      bit g;
      g = m_wel && !exp_lock(m_bp, a);
      wr_addr = a;
      wr_req  = 1'b1;
      tick(1);
      wr_req  = 1'b0;
      check(wr_grant == g && wr_deny == !g, tag, {wr_grant, wr_deny}, {g, !g});
      if (g) begin
         check(write_busy, "R7 busy after grant", write_busy, 1);
         wait_idle();
         m_wel = 1'b0;
      end
      tick(1);
      check(!wr_grant && !wr_deny, "R7 single response", {wr_grant, wr_deny}, 0);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] rx;
      int e, l;
      void'($urandom(32'd4242));
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R11 reset state
      check(!write_busy && !spi_so_en && !wr_grant && !wr_deny, "R11 reset outputs",
            {write_busy, spi_so_en, wr_grant, wr_deny}, 0);
      status_check("R11 R1 reset status", 1'b0);

      // R3 wrong length ignored, then proper latch commands
      send(9, 16'h000C);
      status_check("R3 nine-bit latch ignored", 1'b0);
      latch(1'b1);
      status_check("R3 latch set", 1'b0);
      latch(1'b0);
      status_check("R3 latch clear", 1'b0);

      // R4 status write with latch off is ignored
      status_write(8'h0C);
      status_check("R4 write ignored without latch", 1'b0);

      // R4 R5 status write commits, other data bits dropped, latch cleared
      latch(1'b1);
      status_write(8'hFF);
      status_check("R4 R5 status write bp=11", 1'b0);

      // R3 latch works under full lock; R6 full lock
      latch(1'b1);
      status_check("R3 latch set with bp=11", 1'b0);
      arr(9'h000, "R6 bp=11 low address");
      status_write(8'h04);
      latch(1'b1);
      arr(9'h180, "R6 bp=01 first locked");
      arr(9'h17F, "R6 bp=01 last open");
      latch(1'b1);
      status_write(8'h08);
      latch(1'b1);
      arr(9'h100, "R6 bp=10 first locked");
      arr(9'h0FF, "R6 bp=10 last open");
      arr(9'h010, "R7 request without latch");
      latch(1'b1);
      status_write(8'h00);
      status_check("R4 bp back to 00", 1'b0);

      // R8 R9 activity during a write cycle
      latch(1'b1);
      wr_addr = 9'h1FF; wr_req = 1'b1; tick(1); wr_req = 1'b0;
      check(wr_grant, "R7 grant bp=00 top address", wr_grant, 1);
      send(8, 16'h0004);
      send(16, {8'h01, 8'h0C});
      wr_addr = 9'h000; wr_req = 1'b1; tick(1); wr_req = 1'b0;
      check(wr_deny, "R9 request denied while busy", wr_deny, 1);
      status_check("R8 R9 read while busy", 1'b1);
      wait_idle();
      m_wel = 1'b0;
      status_check("R5 R9 after busy cycle", 1'b0);

      // R10 status-write commit and array grant on the same edge
      latch(1'b1);
      frame_open(16, {8'h01, 8'h0C}, rx, e, l);
      cs_n = 1'b1;
      tick(2);
      wr_addr = 9'h055; wr_req = 1'b1;
      tick(1);
      wr_req = 1'b0;
      check(wr_grant, "R10 array wins tie", wr_grant, 1);
      check(write_busy, "R10 busy from array write", write_busy, 1);
      wait_idle();
      m_wel = 1'b0;
      tick(4);
      status_check("R10 bp unchanged after tie", 1'b0);

      // random mix
      for (int it = 0; it < 40; it++) begin
         int op;
         op = $urandom % 5;
         case (op)
            0: latch(1'b1);
            1: latch(1'b0);
            2: status_write(8'($urandom));
            3: arr(AW'($urandom), "R6 R7 random request");
            default: ;
         endcase
         status_check("R1 random status", 1'b0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule